// File: doc/BRIEF.md
# Split-Transaction Bus Target Dispatcher

This block is a memory-mapped target on a split-transaction command bus. It serves three address spaces: a receive buffer that the media side fills, a transmit buffer that the media side drains, and a small bank of control registers. Commands can arrive on two command buses. The block accepts those addressed to its own target identifier, queues them in an inlet FIFO, and then sorts them in arrival order into a read queue and a write queue. Each queue has its own engine.

A read captures the addressed word at dequeue time. It then requests the push bus and presents the data and the command's tag once the grant arrives. A normal write requests the pull bus, takes the payload in the grant cycle and commits it one cycle later. A fast write carries its data in the upper half of the address field and is written straight to a register, with no pull phase. The inlet raises a nearly-full signal early, so commands already in flight upstream still find room.

Top module: `bus_target_dispatch`

## Requirements
- R1: A command is accepted only when its target identifier equals the TARGET_ID parameter and its kind is not the reserved code 3. Any other command gets no acknowledge and has no effect.
- R2: nearly_full is high whenever the 8-entry inlet holds 6 or more commands, and no command is acknowledged while it is high. With the defaults (read queue depth 4) and the push grant withheld, exactly 11 reads are accepted: 1 in the engine, 4 in the read queue and 6 in the inlet.
- R3: When both buses present acceptable commands in the same cycle, bus 0 is acknowledged and bus 1 is not. At most one acknowledge is high per cycle, and a command that is not acknowledged must be held by its bus.
- R4: Kind codes are 0 = read, 1 = write, 2 = fast write. Reads go to the read queue and both write kinds go to the write queue. Responses leave in acceptance order.
- R5: A read samples its data when it is dequeued. push_req, push_data and push_tag stay unchanged until push_gnt, and push_valid is high exactly in the cycle of the grant.
- R6: A write holds pull_req and pull_tag until pull_gnt. It samples pull_data in the grant cycle and writes it to the target on the following clock edge.
- R7: A fast write takes its data from address bits 31:16, zero-extended, and its register location from bits 15:0. It never raises pull_req.
- R8: Address bit 15 set selects register (low bits as index). Bit 15 clear with bit 14 set selects the receive buffer for reads and the transmit buffer for writes, with the low bits as index.
- R9: An address with bits 15 and 14 both clear reads as zero, and a write to it changes nothing.
- R10: push_tag carries the tag of the read being answered, and pull_tag carries the tag of the write being fetched.
- R11: If a read captures a register in the same cycle that a write commits to that register, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd0_valid | input | 1 | Bus 0 command present |
| cmd0_tid | input | 4 | Bus 0 target identifier |
| cmd0_kind | input | 2 | Bus 0 kind (0 read, 1 write, 2 fast write) |
| cmd0_addr | input | 32 | Bus 0 address field |
| cmd0_tag | input | 4 | Bus 0 reference tag |
| cmd0_ack | output | 1 | Bus 0 command accepted this cycle |
| cmd1_valid | input | 1 | Bus 1 command present |
| cmd1_tid | input | 4 | Bus 1 target identifier |
| cmd1_kind | input | 2 | Bus 1 kind |
| cmd1_addr | input | 32 | Bus 1 address field |
| cmd1_tag | input | 4 | Bus 1 reference tag |
| cmd1_ack | output | 1 | Bus 1 command accepted this cycle |
| nearly_full | output | 1 | Backpressure to the command arbiters |
| push_req | output | 1 | Push bus request |
| push_gnt | input | 1 | Push bus grant |
| push_valid | output | 1 | Push data driven this cycle |
| push_data | output | 32 | Read data |
| push_tag | output | 4 | Tag of the answered read |
| pull_req | output | 1 | Pull bus request |
| pull_gnt | input | 1 | Pull bus grant, pull_data valid |
| pull_tag | output | 4 | Tag of the write being fetched |
| pull_data | input | 32 | Write payload |
| rbuf_we | input | 1 | Media-side receive buffer write |
| rbuf_waddr | input | 4 | Receive buffer write index |
| rbuf_wdata | input | 32 | Receive buffer write data |
| tbuf_raddr | input | 4 | Media-side transmit buffer read index |
| tbuf_rdata | output | 32 | Transmit buffer read data |
| csr_out | output | 128 | All control registers, register i in bits 32*i+31:32*i |

## Verification
Because the read and write engines run independently, a read capture and a write commit can land on the same register in the same cycle. The bench arranges this by holding the pull grant high beforehand, accepting a normal write to register 3 and then, two cycles later, a read of register 3. The write then commits on the very edge at which the read samples. The read must return the old value (R11), a later read must return the new one, and the register port must show the new one. Priority between the two buses is also provoked by presenting both buses in one cycle, and is judged from the acknowledges and the final register contents.

// File: rtl/btd_pkg.sv
package btd_pkg;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 4;
  localparam int LOC_W  = 16;
  localparam int REG_SEL_BIT = 15;
  localparam int BUF_SEL_BIT = 14;

  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_FAST  = 2'd2,
    K_RSVD  = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
  } cmd_t;
endpackage

// File: rtl/btd_fifo.sv
module btd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign rdata = mem[rp_q];

  always_comb begin
    do_push = push && !full;
    do_pop  = pop && !empty;
    wp_d    = do_push ? wp_q + 1'b1 : wp_q;
    rp_d    = do_pop  ? rp_q + 1'b1 : rp_q;
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/btd_rd_eng.sv
module btd_rd_eng
  import btd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  cmd_t             q_head,
  output logic             q_pop,
  output logic [LOC_W-1:0] rd_addr,
  input  logic [DW-1:0]    rd_data,
  input  logic             push_gnt,
  output logic             push_req,
  output logic             push_valid,
  output logic [DW-1:0]    push_data,
  output logic [TAG_W-1:0] push_tag
);
  logic             busy_q, busy_d;
  logic [DW-1:0]    data_q, data_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             unused_rd;

  assign unused_rd = ^{q_head.kind, q_head.addr[ADDR_W-1:LOC_W]};
  assign rd_addr   = q_head.addr[LOC_W-1:0];

  always_comb begin
    busy_d = busy_q;
    data_d = data_q;
    tag_d  = tag_q;
    q_pop  = 1'b0;
    if (!busy_q && !q_empty) begin
      q_pop  = 1'b1;
      busy_d = 1'b1;
      data_d = rd_data;
      tag_d  = q_head.tag;
    end else if (busy_q && push_gnt) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      data_q <= '0;
      tag_q  <= '0;
    end else begin
      busy_q <= busy_d;
      data_q <= data_d;
      tag_q  <= tag_d;
    end
  end

  assign push_req   = busy_q;
  assign push_valid = busy_q && push_gnt;
  assign push_data  = data_q;
  assign push_tag   = tag_q;

  assert_push_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !push_gnt) |=> (push_req && $stable(push_data) && $stable(push_tag)));
  assert_push_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> !push_req || $past(q_pop) == 1'b0);
endmodule

// File: rtl/btd_wr_eng.sv
module btd_wr_eng
  import btd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  cmd_t             q_head,
  output logic             q_pop,
  input  logic             pull_gnt,
  input  logic [DW-1:0]    pull_data,
  output logic             pull_req,
  output logic [TAG_W-1:0] pull_tag,
  output logic             we,
  output logic [LOC_W-1:0] waddr,
  output logic [DW-1:0]    wdata
);
  typedef enum logic [1:0] {W_IDLE, W_PULL, W_COMMIT} wst_e;
  localparam int FD_W = ADDR_W - LOC_W;

  wst_e             st_q, st_d;
  logic [LOC_W-1:0] addr_q, addr_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [DW-1:0]    data_q, data_d;
  logic             fast_now;

  assign fast_now = !q_empty && (st_q == W_IDLE) && (q_head.kind == K_FAST);

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    tag_d  = tag_q;
    data_d = data_q;
    q_pop  = 1'b0;
    case (st_q)
      W_IDLE: if (!q_empty) begin
        q_pop = 1'b1;
        if (q_head.kind != K_FAST) begin
          st_d   = W_PULL;
          addr_d = q_head.addr[LOC_W-1:0];
          tag_d  = q_head.tag;
        end
      end
      W_PULL: if (pull_gnt) begin
        data_d = pull_data;
        st_d   = W_COMMIT;
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      addr_q <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      tag_q  <= tag_d;
      data_q <= data_d;
    end
  end

  assign pull_req = (st_q == W_PULL);
  assign pull_tag = tag_q;
  assign we       = fast_now || (st_q == W_COMMIT);
  assign waddr    = fast_now ? q_head.addr[LOC_W-1:0] : addr_q;
  assign wdata    = fast_now ? DW'(q_head.addr[ADDR_W-1:LOC_W]) : data_q;

  assert_pull_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_req && !pull_gnt) |=> (pull_req && $stable(pull_tag)));
  assert_pull_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_req && pull_gnt) |=> (we && wdata == $past(pull_data)));
  assert_fast_no_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fast_now |=> !pull_req);
  if (FD_W > DW) begin : g_bad_width
    initial $error("fast-write data field wider than data path");
  end
endmodule

// File: rtl/bus_target_dispatch.sv
module bus_target_dispatch
  import btd_pkg::*;
#(
  parameter int          TID_W       = 4,
  parameter logic [3:0]  TARGET_ID   = 4'h5,
  parameter int          DW          = 32,
  parameter int          INLET_DEPTH = 8,
  parameter int          NF_LEVEL    = 6,
  parameter int          RQ_DEPTH    = 4,
  parameter int          WQ_DEPTH    = 4,
  parameter int          RBUF_DEPTH  = 16,
  parameter int          TBUF_DEPTH  = 16,
  parameter int          NCSR        = 4,
  localparam int         RB_IW       = $clog2(RBUF_DEPTH),
  localparam int         TB_IW       = $clog2(TBUF_DEPTH),
  localparam int         CS_IW       = $clog2(NCSR),
  localparam int         IN_CW       = $clog2(INLET_DEPTH + 1),
  localparam int         RQ_CW       = $clog2(RQ_DEPTH + 1),
  localparam int         WQ_CW       = $clog2(WQ_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd0_valid,
  input  logic [TID_W-1:0]     cmd0_tid,
  input  logic [1:0]           cmd0_kind,
  input  logic [ADDR_W-1:0]    cmd0_addr,
  input  logic [TAG_W-1:0]     cmd0_tag,
  output logic                 cmd0_ack,
  input  logic                 cmd1_valid,
  input  logic [TID_W-1:0]     cmd1_tid,
  input  logic [1:0]           cmd1_kind,
  input  logic [ADDR_W-1:0]    cmd1_addr,
  input  logic [TAG_W-1:0]     cmd1_tag,
  output logic                 cmd1_ack,
  output logic                 nearly_full,
  output logic                 push_req,
  input  logic                 push_gnt,
  output logic                 push_valid,
  output logic [DW-1:0]        push_data,
  output logic [TAG_W-1:0]     push_tag,
  output logic                 pull_req,
  input  logic                 pull_gnt,
  output logic [TAG_W-1:0]     pull_tag,
  input  logic [DW-1:0]        pull_data,
  input  logic                 rbuf_we,
  input  logic [RB_IW-1:0]     rbuf_waddr,
  input  logic [DW-1:0]        rbuf_wdata,
  input  logic [TB_IW-1:0]     tbuf_raddr,
  output logic [DW-1:0]        tbuf_rdata,
  output logic [NCSR*DW-1:0]   csr_out
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // target match and fixed-priority acceptance
  logic m0, m1, in_push, in_pop, in_full, in_empty;
  logic [IN_CW-1:0] in_count;
  cmd_t c0, c1, in_wdata, in_head;

  assign c0 = '{kind: kind_e'(cmd0_kind), addr: cmd0_addr, tag: cmd0_tag};
  assign c1 = '{kind: kind_e'(cmd1_kind), addr: cmd1_addr, tag: cmd1_tag};
  assign m0 = cmd0_valid && (cmd0_tid == TARGET_ID) && (c0.kind != K_RSVD);
  assign m1 = cmd1_valid && (cmd1_tid == TARGET_ID) && (c1.kind != K_RSVD);
  assign nearly_full = (in_count >= IN_CW'(NF_LEVEL));
  assign cmd0_ack = m0 && !nearly_full;
  assign cmd1_ack = m1 && !m0 && !nearly_full;
  assign in_push  = cmd0_ack || cmd1_ack;
  assign in_wdata = cmd0_ack ? c0 : c1;

  btd_fifo #(.W($bits(cmd_t)), .DEPTH(INLET_DEPTH)) u_inlet (
    .clk(clk), .rst_n(srst_n), .push(in_push), .wdata(in_wdata), .pop(in_pop),
    .rdata(in_head), .count(in_count), .full(in_full), .empty(in_empty));

  // in-order sort into read and write queues
  logic rq_push, wq_push, rq_pop, wq_pop, rq_full, wq_full, rq_empty, wq_empty;
  logic [RQ_CW-1:0] rq_count;
  logic [WQ_CW-1:0] wq_count;
  cmd_t rq_head, wq_head;

  assign rq_push = !in_empty && (in_head.kind == K_READ) && !rq_full;
  assign wq_push = !in_empty && (in_head.kind != K_READ) && !wq_full;
  assign in_pop  = rq_push || wq_push;

  btd_fifo #(.W($bits(cmd_t)), .DEPTH(RQ_DEPTH)) u_rq (
    .clk(clk), .rst_n(srst_n), .push(rq_push), .wdata(in_head), .pop(rq_pop),
    .rdata(rq_head), .count(rq_count), .full(rq_full), .empty(rq_empty));
  btd_fifo #(.W($bits(cmd_t)), .DEPTH(WQ_DEPTH)) u_wq (
    .clk(clk), .rst_n(srst_n), .push(wq_push), .wdata(in_head), .pop(wq_pop),
    .rdata(wq_head), .count(wq_count), .full(wq_full), .empty(wq_empty));

  // engines
  logic [LOC_W-1:0] rd_addr, waddr;
  logic [DW-1:0]    rd_data, wdata;
  logic             we;

  btd_rd_eng #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(srst_n), .q_empty(rq_empty), .q_head(rq_head), .q_pop(rq_pop),
    .rd_addr(rd_addr), .rd_data(rd_data), .push_gnt(push_gnt), .push_req(push_req),
    .push_valid(push_valid), .push_data(push_data), .push_tag(push_tag));
  btd_wr_eng #(.DW(DW)) u_wr (
    .clk(clk), .rst_n(srst_n), .q_empty(wq_empty), .q_head(wq_head), .q_pop(wq_pop),
    .pull_gnt(pull_gnt), .pull_data(pull_data), .pull_req(pull_req), .pull_tag(pull_tag),
    .we(we), .waddr(waddr), .wdata(wdata));

  // storage and address decode
  logic [DW-1:0] rbuf [RBUF_DEPTH];
  logic [DW-1:0] tbuf [TBUF_DEPTH];
  logic [DW-1:0] csr  [NCSR];
  logic          csr_we, tbuf_we;
  logic          unused_top;

  assign unused_top = ^{rd_addr, waddr, in_full, rq_count, wq_count};
  assign csr_we  = we && waddr[REG_SEL_BIT];
  assign tbuf_we = we && !waddr[REG_SEL_BIT] && waddr[BUF_SEL_BIT];

  always_comb begin
    if (rd_addr[REG_SEL_BIT])      rd_data = csr[rd_addr[CS_IW-1:0]];
    else if (rd_addr[BUF_SEL_BIT]) rd_data = rbuf[rd_addr[RB_IW-1:0]];
    else                           rd_data = '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int i = 0; i < NCSR; i++) csr[i] <= '0;
    end else if (csr_we) begin
      csr[waddr[CS_IW-1:0]] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (tbuf_we) tbuf[waddr[TB_IW-1:0]] <= wdata;
    if (rbuf_we) rbuf[rbuf_waddr] <= rbuf_wdata;
  end

  assign tbuf_rdata = tbuf[tbuf_raddr];
  for (genvar g = 0; g < NCSR; g++) begin : g_csr_out
    assign csr_out[g*DW +: DW] = csr[g];
  end

  assert_one_accept_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({cmd0_ack, cmd1_ack}));
  assert_inlet_bound_R2: assert property (@(posedge clk) disable iff (!srst_n)
    in_count <= IN_CW'(NF_LEVEL));
  assert_sorted_read_R4: assert property (@(posedge clk) disable iff (!srst_n)
    rq_pop |-> rq_head.kind == K_READ);
  assert_sorted_write_R4: assert property (@(posedge clk) disable iff (!srst_n)
    wq_pop |-> wq_head.kind != K_READ);
endmodule

// File: tb/sim_bus_target_dispatch.sv
module sim_bus_target_dispatch;
  logic clk = 1'b0;
  logic rst_n;
  logic cmd0_valid, cmd1_valid, push_gnt, pull_gnt, rbuf_we;
  logic [3:0] cmd0_tid, cmd1_tid, cmd0_tag, cmd1_tag, rbuf_waddr, tbuf_raddr;
  logic [1:0] cmd0_kind, cmd1_kind;
  logic [31:0] cmd0_addr, cmd1_addr, pull_data, rbuf_wdata;
  logic cmd0_ack, cmd1_ack, nearly_full, push_req, push_valid, pull_req;
  logic [31:0] push_data, tbuf_rdata;
  logic [3:0] push_tag, pull_tag;
  logic [127:0] csr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int pull_seen = 0;

  always #10 clk = ~clk;

  bus_target_dispatch u0 (.*);

  always @(negedge clk) if (pull_req) pull_seen++;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rb_val(input int i);
    return 32'hC0DE_0000 + 32'(i * 37);
  endfunction

  task automatic issue(input int bus, input logic [3:0] tid, input logic [1:0] kind,
                       input logic [31:0] addr, input logic [3:0] tag, output logic ack);
    @(negedge clk);
    if (bus == 0) begin
      cmd0_valid = 1; cmd0_tid = tid; cmd0_kind = kind; cmd0_addr = addr; cmd0_tag = tag;
    end else begin
      cmd1_valid = 1; cmd1_tid = tid; cmd1_kind = kind; cmd1_addr = addr; cmd1_tag = tag;
    end
    #5 ack = (bus == 0) ? cmd0_ack : cmd1_ack;
    @(negedge clk);
    cmd0_valid = 0; cmd1_valid = 0;
  endtask

  task automatic collect(input string req, input logic [31:0] exp, input logic [3:0] tag);
    int n = 0;
    while (!push_req && n < 50) begin @(negedge clk); n++; end
    push_gnt = 1;
    #5;
    chk({req, " push_valid"}, 128'(push_valid), 128'(1));
    chk({req, " push_data"}, 128'(push_data), 128'(exp));
    chk({req, " R10 push_tag"}, 128'(push_tag), 128'(tag));
    @(negedge clk);
    push_gnt = 0;
  endtask

  task automatic read_chk(input string req, input logic [15:0] addr, input logic [3:0] tag,
                          input logic [31:0] exp);
    logic a;
    issue(0, 4'h5, 2'd0, {16'h0, addr}, tag, a);
    collect(req, exp, tag);
  endtask

  task automatic write_do(input string req, input logic [15:0] addr, input logic [3:0] tag,
                          input logic [31:0] data);
    logic a;
    int n = 0;
    issue(0, 4'h5, 2'd1, {16'h0, addr}, tag, a);
    while (!pull_req && n < 50) begin @(negedge clk); n++; end
    chk({req, " R10 pull_tag"}, 128'(pull_tag), 128'(tag));
    pull_gnt = 1; pull_data = data;
    @(negedge clk);
    pull_gnt = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, b;
    int acc;
    cmd0_valid = 0; cmd1_valid = 0; cmd0_tid = 0; cmd1_tid = 0; cmd0_kind = 0; cmd1_kind = 0;
    cmd0_addr = 0; cmd1_addr = 0; cmd0_tag = 0; cmd1_tag = 0;
    push_gnt = 0; pull_gnt = 0; pull_data = 0;
    rbuf_we = 0; rbuf_waddr = 0; rbuf_wdata = 0; tbuf_raddr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    chk("R2 reset nearly_full", 128'(nearly_full), 128'(0));
    chk("R5 reset push_req", 128'(push_req), 128'(0));
    chk("R6 reset pull_req", 128'(pull_req), 128'(0));
    chk("R8 reset csr", csr_out, 128'(0));

    for (int i = 0; i < 16; i++) begin
      @(negedge clk); rbuf_we = 1; rbuf_waddr = 4'(i); rbuf_wdata = rb_val(i);
    end
    @(negedge clk); rbuf_we = 0;

    // R8 receive buffer reads, every entry
    for (int i = 0; i < 16; i++) read_chk("R8 rbuf read", 16'h4000 | 16'(i), 4'(i), rb_val(i));

    // R6 / R8 transmit buffer writes, every entry
    for (int i = 0; i < 16; i++)
      write_do("R6 tbuf write", 16'h4000 | 16'(i), 4'(15 - i), 32'h1234_0000 + 32'(i * 7));
    for (int i = 0; i < 16; i++) begin
      tbuf_raddr = 4'(i); #1;
      chk("R8 tbuf content", 128'(tbuf_rdata), 128'(32'h1234_0000 + 32'(i * 7)));
    end

    // R7 fast writes to every register, no pull phase
    pull_seen = 0;
    for (int k = 0; k < 4; k++) issue(k % 2, 4'h5, 2'd2, {16'hBEE0 + 16'(k), 16'h8000 | 16'(k)}, 0, a);
    repeat (4) @(negedge clk);
    chk("R7 no pull_req", 128'(pull_seen), 128'(0));
    for (int k = 0; k < 4; k++)
      chk("R7 fast data", 128'(csr_out[k*32 +: 32]), 128'(32'h0000_BEE0 + 32'(k)));

    // R8 register read back through push bus
    for (int k = 0; k < 4; k++) read_chk("R8 csr read", 16'h8000 | 16'(k), 4'(k), 32'h0000_BEE0 + 32'(k));

    // R9 unmapped space
    read_chk("R9 unmapped read", 16'h0003, 4'h9, 32'h0);
    write_do("R9 unmapped write", 16'h0005, 4'h6, 32'hDEAD_BEEF);
    tbuf_raddr = 4'd5; #1;
    chk("R9 tbuf untouched", 128'(tbuf_rdata), 128'(32'h1234_0000 + 32'(5 * 7)));
    read_chk("R9 rbuf untouched", 16'h4005, 4'h2, rb_val(5));
    chk("R9 csr untouched", 128'(csr_out[31:0]), 128'(32'h0000_BEE0));

    // R1 wrong target and reserved kind
    issue(0, 4'h3, 2'd2, {16'h7777, 16'h8000}, 0, a);
    chk("R1 wrong tid ack", 128'(a), 128'(0));
    issue(1, 4'h5, 2'd3, {16'h7777, 16'h8000}, 0, a);
    chk("R1 reserved kind ack", 128'(a), 128'(0));
    repeat (4) @(negedge clk);
    chk("R1 csr unchanged", 128'(csr_out[31:0]), 128'(32'h0000_BEE0));

    // R3 both buses in one cycle
    @(negedge clk);
    cmd0_valid = 1; cmd0_tid = 5; cmd0_kind = 2; cmd0_addr = {16'h00A0, 16'h8001};
    cmd1_valid = 1; cmd1_tid = 5; cmd1_kind = 2; cmd1_addr = {16'h00B1, 16'h8001};
    #5 a = cmd0_ack; b = cmd1_ack;
    chk("R3 bus0 wins", 128'({a, b}), 128'(2'b10));
    @(negedge clk);
    cmd0_valid = 0;
    #5 b = cmd1_ack;
    chk("R3 bus1 next", 128'(b), 128'(1));
    @(negedge clk);
    cmd1_valid = 0;
    repeat (4) @(negedge clk);
    chk("R3 final order", 128'(csr_out[63:32]), 128'(32'h0000_00B1));

    // R11 read capture and write commit on the same edge
    pull_gnt = 1; pull_data = 32'hFACE_0011;
    issue(0, 4'h5, 2'd1, {16'h0, 16'h8003}, 4'hA, a);
    issue(0, 4'h5, 2'd0, {16'h0, 16'h8003}, 4'hB, b);
    collect("R11 old value", 32'h0000_BEE3, 4'hB);
    pull_gnt = 0;
    repeat (2) @(negedge clk);
    chk("R11 csr new", 128'(csr_out[127:96]), 128'(32'hFACE_0011));
    read_chk("R11 later read", 16'h8003, 4'hC, 32'hFACE_0011);

    // R2 / R4 fill with push grant withheld
    acc = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      cmd0_valid = 1; cmd0_tid = 5; cmd0_kind = 0;
      cmd0_addr = {16'h0, 16'h4000 | 16'(acc)}; cmd0_tag = 4'(acc);
      #5 if (cmd0_ack) acc++;
    end
    @(negedge clk); cmd0_valid = 0;
    chk("R2 accepted count", 128'(acc), 128'(11));
    chk("R2 nearly_full high", 128'(nearly_full), 128'(1));
    for (int i = 0; i < 11; i++) collect("R4 order", rb_val(i), 4'(i));
    repeat (4) @(negedge clk);
    chk("R2 nearly_full low", 128'(nearly_full), 128'(0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule